// File: doc/BRIEF.md
# Switchable Multiply / Triple-Add Arithmetic Slot

This block is one arithmetic slot in a scheduled datapath. It works either as a single unsigned 16x16 multiplier or as three independent 16-bit adders. The operand and result ports of both functions are always wired, but only the function that is currently configured raises its result-valid flag. Results are registered, so they appear one cycle after their operands.

A change of function is modelled as a reconfiguration. The control logic raises an interrupt-style request toward a configuration agent. It then accepts a frame of fixed length (41 words by default), one word per cycle whenever the word strobe is high. After the last word it commits the new function and pulses `cfg_ready`. While this is in progress `busy` is high, no result is flagged valid, and any further function request is dropped. A request for the function that is already active completes at once, with no frame transfer.

Top module: `morph_arith_unit`

## Requirements
- R1: After reset the active function is multiply (`mode_active` = 0), and `busy`, `cfg_irq`, `cfg_ready`, `mul_out_valid` and `add_out_valid` are all low.
- R2: In multiply mode, when `mul_in_valid` is high, one cycle later `mul_out_valid` is high and `mul_p` equals the unsigned 32-bit product `mul_a * mul_b`.
- R3: In add mode (`mode_active` = 1), when `add_in_valid` is high, one cycle later `add_out_valid` is high. Each lane i holds the 17-bit sum (carry kept) at `add_sum[17i+16:17i]` of `add_a[16i+15:16i] + add_b[16i+15:16i]`. The valid flag of the inactive function never rises.
- R4: While `busy` is high, both `mul_out_valid` and `add_out_valid` stay low in the following cycle, whatever the input valid flags are.
- R5: A request (`mode_req_valid`) whose `mode_req_sel` (0 = multiply, 1 = add) differs from the active function sets `busy` and `cfg_irq` on the next cycle. `cfg_irq` drops after the first accepted frame word.
- R6: Exactly FRAME_WORDS cycles with `cfg_beat` high end the transfer; cycles with `cfg_beat` low are not counted. The cycle after the last word, `busy` is low, `mode_active` holds the new function, and `cfg_ready` is high for that single cycle.
- R7: A function request made while `busy` is high is ignored: it neither changes the target function nor restarts the word count.
- R8: A request for the already-active function makes `cfg_ready` high on the next cycle, without raising `busy` or `cfg_irq`.
- R9: `mul_p` and `add_sum` are registered from their operand ports every cycle in either mode, whatever the valid flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req_valid | input | 1 | Function change request strobe |
| mode_req_sel | input | 1 | Requested function, 0 = multiply, 1 = add |
| cfg_beat | input | 1 | One configuration frame word accepted this cycle |
| cfg_irq | output | 1 | Request toward the configuration agent |
| busy | output | 1 | Reconfiguration in progress |
| cfg_ready | output | 1 | One-cycle pulse when a request completes |
| mode_active | output | 1 | Currently usable function |
| mul_in_valid | input | 1 | Multiply operands valid |
| mul_a | input | 16 | Multiplicand |
| mul_b | input | 16 | Multiplier |
| add_in_valid | input | 1 | Adder operands valid |
| add_a | input | 48 | Three packed 16-bit addend lanes |
| add_b | input | 48 | Three packed 16-bit augend lanes |
| mul_out_valid | output | 1 | Product valid |
| mul_p | output | 32 | Registered product |
| add_out_valid | output | 1 | Sums valid |
| add_sum | output | 51 | Three packed 17-bit sums |

## Verification
Products are tried with zero, one and all-ones operands and with mixed values. This tells a full 32-bit product apart from a truncated or signed one. The adder lanes are given operands that carry out of bit 15 in one lane and not in another, and distinct values per lane. This exposes a dropped carry or swapped lane slices. Frame words are fed with gaps and with a stray request in the middle, so that a count of cycles instead of words, or a restart on a new request, moves the commit cycle.

// File: rtl/morph_pkg.sv
package morph_pkg;
    typedef enum logic {
        FN_MUL = 1'b0,
        FN_ADD = 1'b1
    } fn_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } cfg_st_e;
endpackage

// File: rtl/morph_mul.sv
module morph_mul #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    always_comb begin
        p = (2*W)'(a) * (2*W)'(b);
    end
endmodule

// File: rtl/morph_add3.sv
module morph_add3 #(
    parameter int W     = 16,
    parameter int LANES = 3
) (
    input  logic [LANES*W-1:0]     a,
    input  logic [LANES*W-1:0]     b,
    output logic [LANES*(W+1)-1:0] s
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign s[i*(W+1) +: W+1] = (W+1)'(a[i*W +: W]) + (W+1)'(b[i*W +: W]);
    end
endmodule

// File: rtl/morph_cfg_ctrl.sv
module morph_cfg_ctrl
    import morph_pkg::*;
#(
    parameter int FRAME_WORDS = 41
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  fn_e  req_fn,
    input  logic beat,
    output logic busy,
    output logic irq,
    output logic ready,
    output fn_e  mode
);
    localparam int CNT_W = $clog2(FRAME_WORDS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_WORDS - 1);

    typedef struct packed {
        cfg_st_e          st;
        fn_e              mode;
        fn_e              target;
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             ready;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.ready = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_fn == r_q.mode) begin
                        r_d.ready = 1'b1;
                    end else begin
                        r_d.st     = ST_XFER;
                        r_d.target = req_fn;
                        r_d.cnt    = '0;
                        r_d.irq    = 1'b1;
                    end
                end
            end
            default: begin
                if (beat) begin
                    r_d.irq = 1'b0;
                    if (r_q.cnt == LAST) begin
                        r_d.st    = ST_IDLE;
                        r_d.mode  = r_q.target;
                        r_d.cnt   = '0;
                        r_d.ready = 1'b1;
                    end else begin
                        r_d.cnt = CNT_W'(r_q.cnt + 1'b1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, mode: FN_MUL, target: FN_MUL, cnt: '0, irq: 1'b0, ready: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy  = (r_q.st == ST_XFER);
    assign irq   = r_q.irq;
    assign ready = r_q.ready;
    assign mode  = r_q.mode;

    AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST); // R6
    AST_IRQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> busy); // R5
    AST_REQ_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(r_q.target)); // R7
endmodule

// File: rtl/morph_arith_unit.sv
module morph_arith_unit
    import morph_pkg::*;
#(
    parameter int W           = 16,
    parameter int LANES       = 3,
    parameter int FRAME_WORDS = 41
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_req_valid,
    input  logic                     mode_req_sel,
    input  logic                     cfg_beat,
    output logic                     cfg_irq,
    output logic                     busy,
    output logic                     cfg_ready,
    output logic                     mode_active,
    input  logic                     mul_in_valid,
    input  logic [W-1:0]             mul_a,
    input  logic [W-1:0]             mul_b,
    input  logic                     add_in_valid,
    input  logic [LANES*W-1:0]       add_a,
    input  logic [LANES*W-1:0]       add_b,
    output logic                     mul_out_valid,
    output logic [2*W-1:0]           mul_p,
    output logic                     add_out_valid,
    output logic [LANES*(W+1)-1:0]   add_sum
);
    localparam int PW = 2 * W;
    localparam int SW = LANES * (W + 1);

    typedef struct packed {
        logic [PW-1:0] prod;
        logic [SW-1:0] sum;
        logic          mul_v;
        logic          add_v;
    } out_t;

    fn_e           mode;
    logic          busy_w;
    logic [PW-1:0] prod_w;
    logic [SW-1:0] sum_w;
    out_t          o_d, o_q;

    morph_cfg_ctrl #(.FRAME_WORDS(FRAME_WORDS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (mode_req_valid),
        .req_fn    (fn_e'(mode_req_sel)),
        .beat      (cfg_beat),
        .busy      (busy_w),
        .irq       (cfg_irq),
        .ready     (cfg_ready),
        .mode      (mode)
    );

    morph_mul #(.W(W)) u_mul (
        .a (mul_a),
        .b (mul_b),
        .p (prod_w)
    );

    morph_add3 #(.W(W), .LANES(LANES)) u_add (
        .a (add_a),
        .b (add_b),
        .s (sum_w)
    );

    always_comb begin
        o_d       = o_q;
        o_d.prod  = prod_w;
        o_d.sum   = sum_w;
        o_d.mul_v = mul_in_valid && !busy_w && (mode == FN_MUL);
        o_d.add_v = add_in_valid && !busy_w && (mode == FN_ADD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign busy          = busy_w;
    assign mode_active   = mode;
    assign mul_p         = o_q.prod;
    assign add_sum       = o_q.sum;
    assign mul_out_valid = o_q.mul_v;
    assign add_out_valid = o_q.add_v;

    AST_BUSY_MUTES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!mul_out_valid && !add_out_valid)); // R4
    AST_ONE_FN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(mul_out_valid && add_out_valid)); // R3
    AST_MODE_MOVES_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_active) |-> cfg_ready); // R6
    AST_SAME_MODE_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mode_req_valid && (mode_req_sel == mode_active)) |=> (!busy && !cfg_irq && cfg_ready)); // R8
endmodule

// File: tb/morph_arith_unit_bench.sv
module morph_arith_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_req_valid = 1'b0, mode_req_sel = 1'b0, cfg_beat = 1'b0;
    logic        cfg_irq, busy, cfg_ready, mode_active;
    logic        mul_in_valid = 1'b0, add_in_valid = 1'b0;
    logic [15:0] mul_a = '0, mul_b = '0;
    logic [47:0] add_a = '0, add_b = '0;
    logic        mul_out_valid, add_out_valid;
    logic [31:0] mul_p;
    logic [50:0] add_sum;

    int total = 0;
    int bad = 0;
    logic [31:0] mul_exp_q[$];
    logic [50:0] add_exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    morph_arith_unit u_morph_arith_unit (
        .clk(clk), .rst_n(rst_n),
        .mode_req_valid(mode_req_valid), .mode_req_sel(mode_req_sel),
        .cfg_beat(cfg_beat), .cfg_irq(cfg_irq), .busy(busy),
        .cfg_ready(cfg_ready), .mode_active(mode_active),
        .mul_in_valid(mul_in_valid), .mul_a(mul_a), .mul_b(mul_b),
        .add_in_valid(add_in_valid), .add_a(add_a), .add_b(add_b),
        .mul_out_valid(mul_out_valid), .mul_p(mul_p),
        .add_out_valid(add_out_valid), .add_sum(add_sum)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [50:0] sums3(input logic [47:0] a, input logic [47:0] b);
        logic [50:0] s;
        for (int i = 0; i < 3; i++) s[i*17 +: 17] = {1'b0, a[i*16 +: 16]} + {1'b0, b[i*16 +: 16]};
        return s;
    endfunction

    // monitor: pops expected results as valid flags appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (mul_out_valid) begin
                if (mul_exp_q.size() == 0) check(1'b0, "R2 spurious mul valid", 64'(mul_p), 64'h0);
                else begin
                    logic [31:0] e;
                    e = mul_exp_q.pop_front();
                    check(mul_p == e, "R2 product", 64'(mul_p), 64'(e));
                end
            end
            if (add_out_valid) begin
                if (add_exp_q.size() == 0) check(1'b0, "R3 spurious add valid", 64'(add_sum), 64'h0);
                else begin
                    logic [50:0] e;
                    e = add_exp_q.pop_front();
                    check(add_sum == e, "R3 sums", 64'(add_sum), 64'(e));
                end
            end
        end
    end

    // driver: one operand set per cycle; expected results pushed only if the function is usable
    task automatic do_mul(input logic [15:0] a, input logic [15:0] b, input bit expect_out);
        mul_a = a; mul_b = b; mul_in_valid = 1'b1;
        if (expect_out) mul_exp_q.push_back(32'(a) * 32'(b));
        @(negedge clk);
        mul_in_valid = 1'b0;
    endtask

    task automatic do_add(input logic [47:0] a, input logic [47:0] b, input bit expect_out);
        add_a = a; add_b = b; add_in_valid = 1'b1;
        if (expect_out) add_exp_q.push_back(sums3(a, b));
        @(negedge clk);
        add_in_valid = 1'b0;
    endtask

    task automatic request(input logic sel);
        mode_req_valid = 1'b1; mode_req_sel = sel;
        @(negedge clk);
        mode_req_valid = 1'b0;
    endtask

    task automatic beats(input int n);
        for (int i = 0; i < n; i++) begin
            cfg_beat = 1'b1;
            @(negedge clk);
            cfg_beat = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check(1'b0, "watchdog", 64'h0, 64'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mode_active == 1'b0, "R1 mode", 64'(mode_active), 64'h0);
        check({busy, cfg_irq, cfg_ready, mul_out_valid, add_out_valid} == 5'b0, "R1 flags",
              64'({busy, cfg_irq, cfg_ready, mul_out_valid, add_out_valid}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 multiply patterns
        do_mul(16'h0000, 16'h1234, 1'b1);
        do_mul(16'hFFFF, 16'hFFFF, 1'b1);
        do_mul(16'h0001, 16'hBEEF, 1'b1);
        do_mul(16'h1234, 16'h5678, 1'b1);
        // R3 add request in multiply mode gives no add valid
        do_add(48'h0001_0002_0003, 48'h0004_0005_0006, 1'b0);
        @(negedge clk);

        // R9 sums registered in multiply mode with no valid
        add_a = 48'hFFFF_0010_8000; add_b = 48'h0001_0020_8000;
        @(negedge clk);
        check(add_sum == sums3(48'hFFFF_0010_8000, 48'h0001_0020_8000), "R9 sum data wired",
              64'(add_sum), 64'(sums3(48'hFFFF_0010_8000, 48'h0001_0020_8000)));

        // R8 same-function request
        request(1'b0);
        check(cfg_ready == 1'b1, "R8 ready", 64'(cfg_ready), 64'h1);
        check(!busy && !cfg_irq, "R8 no busy/irq", 64'({busy, cfg_irq}), 64'h0);
        @(negedge clk);
        check(cfg_ready == 1'b0, "R8 ready one cycle", 64'(cfg_ready), 64'h0);

        // R5 switch to add
        request(1'b1);
        check(busy && cfg_irq, "R5 busy and irq", 64'({busy, cfg_irq}), 64'h3);
        // R4 operands during busy produce nothing
        do_mul(16'h0003, 16'h0003, 1'b0);
        check(!mul_out_valid && !add_out_valid, "R4 valids low", 64'({mul_out_valid, add_out_valid}), 64'h0);
        // R7 stray request during busy
        request(1'b0);
        beats(1);
        check(cfg_irq == 1'b0, "R5 irq drops after first word", 64'(cfg_irq), 64'h0);
        // gap cycles not counted (R6)
        repeat (3) @(negedge clk);
        beats(FW - 2);
        check(busy == 1'b1, "R6 still busy before last word", 64'(busy), 64'h1);
        request(1'b0);
        check(busy == 1'b1, "R7 request ignored, still busy", 64'(busy), 64'h1);
        beats(1);
        check(!busy && cfg_ready, "R6 commit", 64'({busy, cfg_ready}), 64'h1);
        check(mode_active == 1'b1, "R7 target kept, mode add", 64'(mode_active), 64'h1);
        @(negedge clk);
        check(cfg_ready == 1'b0, "R6 ready single cycle", 64'(cfg_ready), 64'h0);

        // R3 add patterns
        do_add(48'hFFFF_0000_1234, 48'h0001_0000_4321, 1'b1);
        do_add(48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, 1'b1);
        do_add(48'h0102_7FFF_0000, 48'h0304_8001_0000, 1'b1);
        // multiply not usable in add mode
        do_mul(16'h0002, 16'h0002, 1'b0);
        @(negedge clk);
        // R9 product registered in add mode
        check(mul_p == 32'd4, "R9 product data wired", 64'(mul_p), 64'd4);

        // back to multiply
        request(1'b0);
        beats(FW);
        check(mode_active == 1'b0 && cfg_ready, "R6 back to multiply", 64'({mode_active, cfg_ready}), 64'h1);
        do_mul(16'h8000, 16'h0002, 1'b1);
        do_mul(16'hABCD, 16'h0100, 1'b1);
        repeat (3) @(negedge clk);

        check(mul_exp_q.size() == 0, "R2 all products seen", 64'(mul_exp_q.size()), 64'h0);
        check(add_exp_q.size() == 0, "R3 all sums seen", 64'(add_exp_q.size()), 64'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule